// File: doc/BRIEF.md
# System Reset Control Port

This block is a single byte of I/O space through which software asks the platform for a system reset and records which kind of reset it wants. It answers one fixed byte address, 0xCF9 by default. It is reached over a word-wide I/O strobe bus with byte enables, and the byte sits in its little-endian lane: lane 1 of the word at 0xCF8 on a 32-bit bus. A write whose reset-request bit is set sends a one-cycle pulse to the platform reset logic. Any other write keeps only the reset-type bit. Reads return the stored byte.

The bus presents a word address, so the low address bits that select a byte are implied by the byte enables. Write and read strobes are single-cycle. Read data and its acknowledge come back one cycle after the read strobe, and both are zero for any access that does not hit the register. The asynchronous active-low reset clears the register and is released synchronously inside the block, two clock edges after `rst_ni` rises.

Top module: `rstctl_port`

## Requirements
- R1: While reset is asserted, and after it is released, the stored reset-type bit is 0, `reset_req_o` is 0 and a read of the register returns 0.
- R2: A hitting write whose register byte has bit 2 set drives `reset_req_o` high for exactly the one cycle after the write strobe. Each such write cycle yields one pulse cycle, and no pulse appears without such a write.
- R3: A hitting write with bit 2 set leaves the stored reset-type bit unchanged.
- R4: A hitting write with bit 2 clear stores bit 1 of the register byte as the reset-type bit. Every other stored bit reads back as 0.
- R5: A hitting read raises `rd_ack_o` in the following cycle with the stored byte in its lane of `rd_data_o` (bits 15:8 on the default 32-bit bus). All other bits of `rd_data_o` are 0.
- R6: Accesses to any other word address cause no pulse, no change to the stored bit, no acknowledge and all-zero read data.
- R7: Accesses to the right word whose byte enable for the register's lane is low are ignored in the same way, whatever the other lanes carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_waddr_i | input | ADDR_W-log2(BUS_BYTES) (14) | Word address of the access |
| io_be_i | input | BUS_BYTES (4) | Byte enables, bit n selects lane n |
| io_wdata_i | input | 8*BUS_BYTES (32) | Write data, little-endian lanes |
| io_wr_i | input | 1 | Single-cycle write strobe |
| io_rd_i | input | 1 | Single-cycle read strobe |
| rd_data_o | output | 8*BUS_BYTES (32) | Read data, valid with rd_ack_o, else 0 |
| rd_ack_o | output | 1 | Read of the register answered this cycle |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions check on every cycle that each request pulse follows a qualifying write and only such a write, and that a reset request write leaves the type bit alone. They also check that a non-request write stores the written type bit, that cycles without a hitting write change nothing, and that read data outside an acknowledged read, or outside the register lane, stays zero. Only the bench's scenarios show the externally visible values. These are the exact byte read back after a sequence of writes, the choice of lane from the address and byte enables under garbage in the other lanes, back-to-back request writes, and the clearing effect of a reset applied in the middle of operation.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  // Bit positions inside the register byte; software depends on them.
  localparam int unsigned KICK_BIT = 2;
  localparam int unsigned TYPE_BIT = 1;

  // Word address and lane of a byte address on a bus of a given width.
  function automatic int unsigned lane_of(input int unsigned byte_addr,
                                          input int unsigned bus_bytes);
    return byte_addr % bus_bytes;
  endfunction

  function automatic int unsigned word_of(input int unsigned byte_addr,
                                          input int unsigned bus_bytes);
    return byte_addr / bus_bytes;
  endfunction
endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode #(
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned WADDR_W   = 14,
  parameter int unsigned REG_WORD  = 0,
  parameter int unsigned REG_LANE  = 0
) (
  input  logic [WADDR_W-1:0]     waddr_i,
  input  logic [BUS_BYTES-1:0]   be_i,
  input  logic [8*BUS_BYTES-1:0] wdata_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  output logic                   wr_hit_o,
  output logic                   rd_hit_o,
  output logic                   kick_bit_o,
  output logic                   type_bit_o
);
  import rstctl_pkg::*;

  localparam logic [WADDR_W-1:0] MATCH = WADDR_W'(REG_WORD);

  logic       lane_sel;
  logic [7:0] lane_byte;

  // Pick the register's lane out of the bus.
  always_comb begin
    lane_sel  = 1'b0;
    lane_byte = 8'h00;
    for (int i = 0; i < int'(BUS_BYTES); i++) begin
      if (i == int'(REG_LANE)) begin
        lane_sel  = be_i[i];
        lane_byte = wdata_i[i*8 +: 8];
      end
    end
  end

  always_comb begin
    wr_hit_o   = wr_i && lane_sel && (waddr_i == MATCH);
    rd_hit_o   = rd_i && lane_sel && (waddr_i == MATCH);
    kick_bit_o = lane_byte[KICK_BIT];
    type_bit_o = lane_byte[TYPE_BIT];
  end
endmodule

// File: rtl/rstctl_reg.sv
module rstctl_reg (
  input  logic clk_i,
  input  logic rst_n,
  input  logic wr_hit_i,
  input  logic kick_bit_i,
  input  logic type_bit_i,
  output logic type_q_o,
  output logic req_q_o
);
  logic kick;
  logic type_d;
  logic req_d;

  // Next state
  always_comb begin
    kick   = wr_hit_i && kick_bit_i;
    req_d  = kick;
    type_d = type_q_o;
    if (wr_hit_i && !kick_bit_i) begin
      type_d = type_bit_i;
    end
  end

  // State
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      type_q_o <= 1'b0;
      req_q_o  <= 1'b0;
    end else begin
      type_q_o <= type_d;
      req_q_o  <= req_d;
    end
  end

  AST_KICK_PULSES: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_hit_i && kick_bit_i) |=> req_q_o); // R2
  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    req_q_o |-> $past(wr_hit_i && kick_bit_i)); // R2
  AST_KICK_HOLDS_TYPE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_hit_i && kick_bit_i) |=> $stable(type_q_o)); // R3
  AST_STORE_TAKES_BIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_hit_i && !kick_bit_i) |=> (type_q_o == $past(type_bit_i))); // R4
endmodule

// File: rtl/rstctl_rdpath.sv
module rstctl_rdpath #(
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned REG_LANE  = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_n,
  input  logic                   rd_hit_i,
  input  logic                   type_q_i,
  output logic [8*BUS_BYTES-1:0] rd_data_o,
  output logic                   rd_ack_o
);
  import rstctl_pkg::*;

  localparam int unsigned BUS_W = 8 * BUS_BYTES;

  logic [7:0]       reg_byte;
  logic [BUS_W-1:0] data_d;

  always_comb begin
    reg_byte           = 8'h00;
    reg_byte[TYPE_BIT] = type_q_i;
    data_d             = '0;
    if (rd_hit_i) begin
      data_d[REG_LANE*8 +: 8] = reg_byte;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o <= '0;
      rd_ack_o  <= 1'b0;
    end else begin
      rd_data_o <= data_d;
      rd_ack_o  <= rd_hit_i;
    end
  end
endmodule

// File: rtl/rstctl_port.sv
module rstctl_port #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned REG_ADDR  = 32'h0CF9,
  localparam int unsigned LANE_W   = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 0,
  localparam int unsigned WADDR_W  = ADDR_W - LANE_W,
  localparam int unsigned BUS_W    = 8 * BUS_BYTES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WADDR_W-1:0] io_waddr_i,
  input  logic [BUS_BYTES-1:0] io_be_i,
  input  logic [BUS_W-1:0]   io_wdata_i,
  input  logic               io_wr_i,
  input  logic               io_rd_i,
  output logic [BUS_W-1:0]   rd_data_o,
  output logic               rd_ack_o,
  output logic               reset_req_o
);
  import rstctl_pkg::*;

  localparam int unsigned REG_LANE = lane_of(REG_ADDR, BUS_BYTES);
  localparam int unsigned REG_WORD = word_of(REG_ADDR, BUS_BYTES);
  localparam logic [BUS_W-1:0] TYPE_MASK = BUS_W'(1) << (REG_LANE*8 + TYPE_BIT);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  logic wr_hit;
  logic rd_hit;
  logic kick_bit;
  logic type_bit;
  logic type_q;

  rstctl_decode #(
    .BUS_BYTES (BUS_BYTES),
    .WADDR_W   (WADDR_W),
    .REG_WORD  (REG_WORD),
    .REG_LANE  (REG_LANE)
  ) decode_i (
    .waddr_i    (io_waddr_i),
    .be_i       (io_be_i),
    .wdata_i    (io_wdata_i),
    .wr_i       (io_wr_i),
    .rd_i       (io_rd_i),
    .wr_hit_o   (wr_hit),
    .rd_hit_o   (rd_hit),
    .kick_bit_o (kick_bit),
    .type_bit_o (type_bit)
  );

  rstctl_reg reg_i (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .wr_hit_i   (wr_hit),
    .kick_bit_i (kick_bit),
    .type_bit_i (type_bit),
    .type_q_o   (type_q),
    .req_q_o    (reset_req_o)
  );

  rstctl_rdpath #(
    .BUS_BYTES (BUS_BYTES),
    .REG_LANE  (REG_LANE)
  ) rdpath_i (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .rd_hit_i  (rd_hit),
    .type_q_i  (type_q),
    .rd_data_o (rd_data_o),
    .rd_ack_o  (rd_ack_o)
  );

  AST_MISS_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_hit |=> !rd_ack_o); // R6
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_ack_o |-> (rd_data_o == '0)); // R6
  AST_MISS_HOLDS_TYPE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_hit |=> $stable(type_q)); // R7
  AST_READ_LANE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_ack_o |-> ((rd_data_o & ~TYPE_MASK) == '0)); // R5
  AST_RESET_CLEAN: assert property (@(posedge clk_i)
    !rst_n |-> (!reset_req_o && !rd_ack_o)); // R1
endmodule

// File: tb/rstctl_port_tb.sv
module rstctl_port_tb_top;
  localparam int WA = 14;
  localparam logic [WA-1:0] HIT  = 14'h33E;  // word holding 0xCF9
  localparam logic [WA-1:0] MISS = 14'h33F;  // word at 0xCFC

  typedef struct packed {
    logic          wr;
    logic [WA-1:0] wa;
    logic [3:0]    be;
    logic [31:0]   data;
    logic          exp_req;
    logic          exp_ack;
    logic [31:0]   exp_rd;
    logic [3:0]    tag;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, HIT,  4'b0010, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 4'd1}, // R1 reads 0
    '{1'b1, HIT,  4'b0010, 32'h0000_FF00, 1'b1, 1'b0, 32'h0000_0000, 4'd2}, // R2 kick
    '{1'b0, HIT,  4'b0010, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 4'd3}, // R3 unchanged
    '{1'b1, HIT,  4'b0010, 32'h0000_FB00, 1'b0, 1'b0, 32'h0000_0000, 4'd4}, // R4 store
    '{1'b0, HIT,  4'b0010, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0200, 4'd4},
    '{1'b1, HIT,  4'b0010, 32'h0000_0600, 1'b1, 1'b0, 32'h0000_0000, 4'd2}, // R2
    '{1'b0, HIT,  4'b0010, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0200, 4'd3}, // R3
    '{1'b1, MISS, 4'b0010, 32'h0000_0400, 1'b0, 1'b0, 32'h0000_0000, 4'd6}, // R6
    '{1'b1, MISS, 4'b0010, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 4'd6},
    '{1'b0, MISS, 4'b0010, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 4'd6},
    '{1'b0, HIT,  4'b0010, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0200, 4'd6},
    '{1'b1, HIT,  4'b1101, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 4'd7}, // R7
    '{1'b1, HIT,  4'b1101, 32'h0404_0404, 1'b0, 1'b0, 32'h0000_0000, 4'd7},
    '{1'b0, HIT,  4'b0010, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0200, 4'd7},
    '{1'b0, HIT,  4'b1101, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 4'd7},
    '{1'b1, HIT,  4'b1111, 32'hFFFF_01FF, 1'b0, 1'b0, 32'h0000_0000, 4'd4},
    '{1'b0, HIT,  4'b1111, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 4'd5}, // R5
    '{1'b1, HIT,  4'b0010, 32'hFFFF_02FF, 1'b0, 1'b0, 32'h0000_0000, 4'd4},
    '{1'b0, HIT,  4'b1111, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0200, 4'd5},
    '{1'b1, HIT,  4'b0010, 32'h0404_0404, 1'b1, 1'b0, 32'h0000_0000, 4'd2},
    '{1'b0, HIT,  4'b0010, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0200, 4'd3}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [WA-1:0] io_waddr_i;
  logic [3:0]    io_be_i;
  logic [31:0]   io_wdata_i;
  logic          io_wr_i;
  logic          io_rd_i;
  logic [31:0]   rd_data_o;
  logic          rd_ack_o;
  logic          reset_req_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  rstctl_port dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_waddr_i  (io_waddr_i),
    .io_be_i     (io_be_i),
    .io_wdata_i  (io_wdata_i),
    .io_wr_i     (io_wr_i),
    .io_rd_i     (io_rd_i),
    .rd_data_o   (rd_data_o),
    .rd_ack_o    (rd_ack_o),
    .reset_req_o (reset_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    io_wr_i = 1'b0; io_rd_i = 1'b0; io_be_i = 4'b0000;
    io_waddr_i = '0; io_wdata_i = '0;
  endtask

  // Drive one strobe cycle; returns at the negedge after the capturing edge.
  task automatic access(input logic wr, input logic [WA-1:0] wa,
                        input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    io_wr_i = wr; io_rd_i = !wr; io_waddr_i = wa; io_be_i = be; io_wdata_i = d;
    @(negedge clk_i);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 req in reset", {31'b0, reset_req_o}, 32'h0);
    check("R1 ack in reset", {31'b0, rd_ack_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    for (int k = 0; k < NV; k++) begin
      string tg;
      tg = $sformatf("R%0d vec %0d", VEC[k].tag, k);
      access(VEC[k].wr, VEC[k].wa, VEC[k].be, VEC[k].data);
      check({tg, " req"},  {31'b0, reset_req_o}, {31'b0, VEC[k].exp_req});
      check({tg, " ack"},  {31'b0, rd_ack_o},    {31'b0, VEC[k].exp_ack});
      check({tg, " data"}, rd_data_o,            VEC[k].exp_rd);
      @(negedge clk_i);
      check({tg, " pulse ends"}, {31'b0, reset_req_o}, 32'h0);  // R2
      check({tg, " ack ends"},   {31'b0, rd_ack_o},    32'h0);
    end

    // R2: back-to-back request writes, one pulse cycle per write
    @(negedge clk_i);
    io_wr_i = 1'b1; io_waddr_i = HIT; io_be_i = 4'b0010; io_wdata_i = 32'h0000_0400;
    @(negedge clk_i);
    check("R2 first pulse", {31'b0, reset_req_o}, 32'h1);
    @(negedge clk_i);
    idle();
    check("R2 second pulse", {31'b0, reset_req_o}, 32'h1);
    @(negedge clk_i);
    check("R2 pulse drops", {31'b0, reset_req_o}, 32'h0);

    // R1: reset in mid-operation clears the stored type bit
    access(1'b1, HIT, 4'b0010, 32'h0000_0200);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 req cleared", {31'b0, reset_req_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    access(1'b0, HIT, 4'b0010, 32'h0);
    check("R1 type cleared", rd_data_o, 32'h0);
    check("R1 ack after reset", {31'b0, rd_ack_o}, 32'h1);

    finish_run();
  end
endmodule